// File: doc/BRIEF.md
# Write-Protection Key Gate and Initialization Handshake

This block guards the writable state of a real-time clock. Software must first send a fixed two-byte key to a key port before any protected register accepts a write. Any other key byte closes the gate again at once. While the gate is open, software can request initialization mode. The block then raises a ready flag once a set number of slow-clock ticks have passed. Only in that state can the calendar year be loaded.

A second flag tells software when the calendar shadow values are valid. Software clears it by writing zero. It is also held low while initialization mode is requested. It comes back after a set number of slow-clock ticks. A sticky flag records that a nonzero year has been loaded, and only reset clears it.

The block runs on the bus clock. The slow RTC clock enters as a one-cycle tick strobe on `rtc_tick`. Writes use a simple interface of enable, address and data, and each write takes one cycle. Address 0 is the control register, address 1 is the key port, address 2 is the year register, and address 3 is not decoded.

Top module: `rtc_guard_ctrl`

## Requirements
- R1: A key-port write of 0xCA followed by a key-port write of 0x53 sets `unlocked` on the clock edge that accepts the 0x53. Writes to other addresses between the two key bytes do not break the sequence.
- R2: While the gate is open or half-open, any key byte other than the expected next one clears `unlocked` on the edge that accepts it. A byte of 0xCA always restarts the sequence, so 0xCA, 0xCA, 0x53 still unlocks.
- R3: A 0x53 key byte that does not directly follow a 0xCA key byte leaves `unlocked` low.
- R4: While `unlocked` is low, control and year writes are ignored. `init_req`, `year` and `sync_ok` keep their values.
- R5: A control write with bit 7 set, made while unlocked, sets `init_req` on the next edge. `init_ready` rises on the edge after the INIT_TICKS-th tick counted while `init_req` is high.
- R6: A control write with bit 7 clear, made while unlocked, clears `init_req` and `init_ready` on the same edge. A later request counts its ticks again from zero.
- R7: Repeating a control write with bit 7 set while `init_ready` is high keeps `init_ready` high without a new delay.
- R8: `sync_ok` is low whenever `init_req` is high. An unlocked control write with bit 5 clear clears `sync_ok`. `sync_ok` sets again on the edge after SYNC_TICKS ticks with no request and no further clear. Writing bit 5 as 1 does not set it.
- R9: A year write is accepted only while unlocked and `init_ready` is high. Loading a nonzero year sets `init_done`, which stays high until reset.
- R10: After reset, all of the following are 0: `unlocked`, `init_req`, `init_ready`, `sync_ok`, `init_done` and `year`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low power-on reset |
| rtc_tick | input | 1 | One-cycle strobe per slow RTC clock period |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (2) | Register select: 0 control, 1 key, 2 year |
| wr_data | input | DW (8) | Write data |
| unlocked | output | 1 | Protected writes are accepted |
| init_req | output | 1 | Initialization mode requested (control bit 7) |
| init_ready | output | 1 | Initialization mode entered (control bit 6) |
| sync_ok | output | 1 | Calendar shadow values valid (control bit 5) |
| init_done | output | 1 | A nonzero year has been loaded since reset (control bit 4) |
| year | output | DW (8) | Loaded year value |

## Verification
The following results appear on the clock edge that accepts the write: `unlocked`, `init_req`, `year`, `init_done`, and the clearing of `init_ready` or `sync_ok`. The rising edges of `init_ready` and `sync_ok` arrive one edge after the last required tick, and the bench places its ticks on every third cycle so that this tick count matters. A behavioural model steps forward on each rising edge from the same inputs. The outputs are compared with it at every falling edge, half a cycle after they settle. The directed checks are also sampled at the falling edge right after each write, or after a wait of fixed length that is longer than the tick delay.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_KEY   = 1;
    localparam int ADDR_YEAR  = 2;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    localparam int BIT_REQ  = 7;
    localparam int BIT_RDY  = 6;
    localparam int BIT_SYNC = 5;
    localparam int BIT_DONE = 4;
endpackage

// File: rtl/rtc_key_gate.sv
module rtc_key_gate
    import rtc_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       open
);
    typedef struct packed {
        lock_e st;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (key_wr) begin
            if (key_byte == KEY_FIRST)
                s_d.st = LK_HALF;
            else if (key_byte == KEY_SECOND && s_q.st == LK_HALF)
                s_d.st = LK_OPEN;
            else
                s_d.st = LK_SHUT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: LK_SHUT};
        else        s_q <= s_d;
    end

    assign open = (s_q.st == LK_OPEN);
endmodule

// File: rtl/rtc_tick_delay.sv
module rtc_tick_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clr,
    output logic flag
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } dly_t;

    dly_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt  = '0;
            s_d.flag = 1'b0;
        end else if (run && !s_q.flag && tick) begin
            if (s_q.cnt == CW'(DLY - 1)) begin
                s_d.flag = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/rtc_guard_ctrl.sv
module rtc_guard_ctrl
    import rtc_guard_pkg::*;
#(
    parameter int INIT_TICKS = 2,
    parameter int SYNC_TICKS = 2,
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rtc_tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          unlocked,
    output logic          init_req,
    output logic          init_ready,
    output logic          sync_ok,
    output logic          init_done,
    output logic [DW-1:0] year
);
    typedef struct packed {
        logic          req;
        logic          done;
        logic [DW-1:0] yr;
    } ctl_t;

    ctl_t s_d, s_q;

    logic key_wr, ctrl_wr, year_wr;
    logic init_clr, sync_clr;

    assign key_wr  = wr_en && (wr_addr == AW'(ADDR_KEY));
    assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL)) && unlocked;
    assign year_wr = wr_en && (wr_addr == AW'(ADDR_YEAR)) && unlocked && init_ready;

    rtc_key_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (wr_data[7:0]),
        .open     (unlocked)
    );

    assign init_clr = !s_q.req || (ctrl_wr && !wr_data[BIT_REQ]);
    assign sync_clr = s_q.req || (ctrl_wr && (!wr_data[BIT_SYNC] || wr_data[BIT_REQ]));

    rtc_tick_delay #(.DLY(INIT_TICKS)) u_init_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rtc_tick),
        .run   (s_q.req),
        .clr   (init_clr),
        .flag  (init_ready)
    );

    rtc_tick_delay #(.DLY(SYNC_TICKS)) u_sync_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rtc_tick),
        .run   (!s_q.req),
        .clr   (sync_clr),
        .flag  (sync_ok)
    );

    always_comb begin
        s_d = s_q;
        if (ctrl_wr)
            s_d.req = wr_data[BIT_REQ];
        if (year_wr) begin
            s_d.yr = wr_data;
            if (wr_data != '0)
                s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign init_req  = s_q.req;
    assign init_done = s_q.done;
    assign year      = s_q.yr;
endmodule

// File: rtl/rtc_guard_ctrl_chk.sv
module rtc_guard_ctrl_chk
    import rtc_guard_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rtc_tick,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          unlocked,
    input logic          init_req,
    input logic          init_ready,
    input logic          sync_ok,
    input logic          init_done,
    input logic [DW-1:0] year
);
    assert_unlock_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == AW'(ADDR_KEY) && wr_data[7:0] == KEY_SECOND));

    assert_wrong_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_KEY) && wr_data[7:0] != KEY_SECOND) |=> !unlocked);

    assert_locked_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_CTRL) && !unlocked) |=> $stable(init_req));

    assert_locked_year_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_YEAR) && !unlocked) |=> $stable(year));

    assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_ready) |-> (init_req && $past(rtc_tick)));

    assert_ready_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> init_req);

    assert_ready_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ready && unlocked && wr_en && wr_addr == AW'(ADDR_CTRL) && wr_data[BIT_REQ]) |=> init_ready);

    assert_sync_low_in_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> !sync_ok);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind rtc_guard_ctrl rtc_guard_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rtc_tick   (rtc_tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .unlocked   (unlocked),
    .init_req   (init_req),
    .init_ready (init_ready),
    .sync_ok    (sync_ok),
    .init_done  (init_done),
    .year       (year)
);

// File: tb/rtc_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_guard_ctrl_tb_top;
    localparam int INIT_T = 2;
    localparam int SYNC_T = 2;
    localparam int WD_LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       unlocked, init_req, init_ready, sync_ok, init_done;
    logic [7:0] year;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit tick_en = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int       m_lock = 0;   // 0 shut, 1 half, 2 open
    bit       m_req = 0, m_rdy = 0, m_sync = 0, m_done = 0;
    int       m_icnt = 0, m_scnt = 0;
    bit [7:0] m_year = 0;

    always #10 clk = ~clk;

    rtc_guard_ctrl #(.INIT_TICKS(INIT_T), .SYNC_TICKS(SYNC_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .unlocked(unlocked), .init_req(init_req), .init_ready(init_ready),
        .sync_ok(sync_ok), .init_done(init_done), .year(year)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_lock = 0; m_req = 0; m_rdy = 0; m_sync = 0; m_done = 0;
            m_icnt = 0; m_scnt = 0; m_year = 0;
        end else begin
            bit kw, cw, yw, nreq, clr_i, clr_s;
            int nlock;
            kw = wr_en && wr_addr == 2'd1;
            cw = wr_en && wr_addr == 2'd0 && m_lock == 2;
            yw = wr_en && wr_addr == 2'd2 && m_lock == 2 && m_rdy;
            nlock = m_lock;
            if (kw) begin
                if (wr_data == 8'hCA) nlock = 1;
                else if (wr_data == 8'h53 && m_lock == 1) nlock = 2;
                else nlock = 0;
            end
            nreq = cw ? wr_data[7] : m_req;
            clr_i = !m_req || (cw && !wr_data[7]);
            if (clr_i) begin m_rdy = 0; m_icnt = 0; end
            else if (!m_rdy && rtc_tick) begin
                if (m_icnt == INIT_T - 1) begin m_rdy = 1; m_icnt = 0; end
                else m_icnt++;
            end
            clr_s = m_req || (cw && (!wr_data[5] || wr_data[7]));
            if (clr_s) begin m_sync = 0; m_scnt = 0; end
            else if (!m_sync && rtc_tick) begin
                if (m_scnt == SYNC_T - 1) begin m_sync = 1; m_scnt = 0; end
                else m_scnt++;
            end
            if (yw) begin
                m_year = wr_data;
                if (wr_data != 0) m_done = 1;
            end
            m_lock = nlock;
            m_req = nreq;
        end
    end

    // tick drive and per-cycle comparison away from the active edge
    always @(negedge clk) begin
        rtc_tick = tick_en && (cyc % 3 == 0);
        if (rst_n && !finished) begin
            check("R1", unlocked, m_lock == 2);
            check("R5", init_req, m_req);
            check("R5", init_ready, m_rdy);
            check("R8", sync_ok, m_sync);
            check("R9", init_done, m_done);
            check("R9", year, m_year);
        end
    end

    always @(posedge clk) begin
        if (cyc >= WD_LIMIT && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R10", unlocked, 0);
        check("R10", init_req, 0);
        check("R10", init_ready, 0);
        check("R10", sync_ok, 0);
        check("R10", init_done, 0);
        check("R10", year, 0);
        tick_en = 1'b1;
        idle(8);
        check("R8", sync_ok, 1);

        wr(2'd1, 8'h53);
        check("R3", unlocked, 0);

        wr(2'd1, 8'hCA);
        wr(2'd0, 8'h80);
        check("R4", init_req, 0);
        wr(2'd1, 8'h53);
        check("R1", unlocked, 1);

        wr(2'd0, 8'h80);
        check("R5", init_req, 1);
        check("R8", sync_ok, 0);
        check("R5", init_ready, 0);
        idle(10);
        check("R5", init_ready, 1);

        wr(2'd2, 8'h24);
        check("R9", year, 8'h24);
        check("R9", init_done, 1);

        wr(2'd0, 8'h80);
        check("R7", init_ready, 1);

        wr(2'd0, 8'h20);
        check("R6", init_req, 0);
        check("R6", init_ready, 0);
        idle(10);
        check("R8", sync_ok, 1);

        wr(2'd0, 8'h20);
        check("R8", sync_ok, 1);
        wr(2'd0, 8'h00);
        check("R8", sync_ok, 0);
        idle(10);
        check("R8", sync_ok, 1);

        wr(2'd2, 8'h11);
        check("R9", year, 8'h24);

        wr(2'd1, 8'hFF);
        check("R2", unlocked, 0);
        wr(2'd2, 8'h00);
        check("R4", year, 8'h24);
        wr(2'd0, 8'h00);
        check("R4", sync_ok, 1);

        wr(2'd1, 8'hCA);
        wr(2'd1, 8'hCA);
        wr(2'd1, 8'h53);
        check("R2", unlocked, 1);
        wr(2'd1, 8'h53);
        check("R2", unlocked, 0);
        wr(2'd1, 8'hCA);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'h53);
        check("R3", unlocked, 0);

        wr(2'd1, 8'hCA);
        wr(2'd1, 8'h53);
        wr(2'd0, 8'h80);
        idle(10);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h80);
        idle(2);
        check("R6", init_ready, 0);
        idle(10);
        check("R6", init_ready, 1);
        check("R9", init_done, 1);

        do_reset();
        check("R9", init_done, 0);
        check("R10", year, 0);

        idle(4);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule